// File: doc/BRIEF.md
# Write-Once Tag Identifier Registers

This block keeps the two one-byte identifiers of a contactless memory tag: a family code that names the application the tag serves, and a format code that tells a reader how the tag's data is laid out. Each register accepts exactly one write after reset of the model. The first write stores the byte and sets that register's lock. Any later write leaves the stored byte alone and raises a one-cycle error pulse. A register-backed lock bit stands in for the permanent storage a real tag would use.

The block also decides whether a selection request addresses this tag. The request may carry a family byte. Its upper nibble names an application and its lower nibble names a subfamily. A zero in either nibble means "any". A request that carries no family byte always addresses the tag. The decision is registered and is returned one clock after the request.

Top module: `tag_ident_regs`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `fam_id`, `fmt_id`, `fam_lock`, `fmt_lock`, `fam_wr_err`, `fmt_wr_err`, `sel_done` and `sel_hit` are all 0.
- R2: A `fam_wr` strobe while `fam_lock` is 0 makes `fam_id` equal `wr_byte` and sets `fam_lock` on the next cycle, and `fam_lock` then stays 1.
- R3: A `fam_wr` strobe while `fam_lock` is 1 leaves `fam_id` unchanged and drives `fam_wr_err` high for exactly the next cycle. Back-to-back strobes give one pulse cycle per strobe.
- R4: A `fmt_wr` strobe while `fmt_lock` is 0 makes `fmt_id` equal `wr_byte` and sets `fmt_lock` on the next cycle, and `fmt_lock` then stays 1.
- R5: A `fmt_wr` strobe while `fmt_lock` is 1 leaves `fmt_id` unchanged and drives `fmt_wr_err` high for exactly the next cycle.
- R6: The two registers are independent. A strobe to one never changes the other's value, lock or error output, and both may be strobed in the same cycle.
- R7: `sel_done` is high exactly in the cycle after a cycle with `sel_valid` high. `sel_hit` is 0 whenever `sel_done` is 0.
- R8: The upper nibble `sel_id[7:4]` passes when it is 0 or equals `fam_id[7:4]`.
- R9: The lower nibble `sel_id[3:0]` passes when it is 0 or equals `fam_id[3:0]`. `sel_hit` is 1 only when both nibbles pass.
- R10: With `sel_has_id` at 0 the request always hits, whatever `sel_id` holds.
- R11: The match uses the value `fam_id` holds in the request cycle. A family write in that same cycle only affects later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fam_wr | input | 1 | Write strobe for the family register |
| fmt_wr | input | 1 | Write strobe for the format register |
| wr_byte | input | 8 | Data shared by both write strobes |
| fam_id | output | 8 | Stored family code |
| fmt_id | output | 8 | Stored format code |
| fam_lock | output | 1 | Family register has been programmed |
| fmt_lock | output | 1 | Format register has been programmed |
| fam_wr_err | output | 1 | One-cycle pulse: write to a locked family register |
| fmt_wr_err | output | 1 | One-cycle pulse: write to a locked format register |
| sel_valid | input | 1 | Selection request present this cycle |
| sel_has_id | input | 1 | Request carries a family byte |
| sel_id | input | 8 | Requested family byte |
| sel_done | output | 1 | Match result valid, one cycle after the request |
| sel_hit | output | 1 | Request addresses this tag |

## Verification
Every result appears one clock edge after its stimulus. A write strobe shows up in the stored value, the lock and the error pulse on the following cycle. A request shows up in `sel_done` and `sel_hit` on the following cycle, and the match uses the family value held before any write in the same cycle. The bench drives inputs and samples outputs on the falling edge. A behavioural model updates on each rising edge, so after each edge the model and the design are compared for that one-edge latency with no extra delay. Directed sequences cover the wildcard nibbles, a write and a request in the same cycle, simultaneous writes and repeated locked writes.

// File: rtl/tag_ident_pkg.sv
// Package: shared widths and register indices for the tag identifier block.
// Assumes identifiers are a whole number of nibble-sized fields.
package tag_ident_pkg;
    localparam int unsigned ID_W     = 8;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned NUM_REGS = 2;

    // Index of each write-once register within the bank.
    typedef enum logic [0:0] {
        REG_FAM = 1'b0,
        REG_FMT = 1'b1
    } reg_idx_e;
endpackage

// File: rtl/wo_byte_reg.sv
// Module: one write-once register with its lock and error pulse.
// The first strobe while unlocked stores the data and locks.
// A strobe while locked keeps the value and pulses err for one cycle.
// Assumes a synchronous active-low reset that models a blank tag.
module wo_byte_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] value,
    output logic         locked,
    output logic         err
);
    // Store on the first write, refuse and flag later ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            locked <= 1'b0;
            err    <= 1'b0;
        end else begin
            err <= wr && locked;
            if (wr && !locked) begin
                value  <= din;
                locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/family_match.sv
// Module: decides whether a selection request addresses the tag.
// The identifier is split into FIELD_W-wide fields. A zero request field
// matches anything, any other value must equal the stored field.
// A request without an identifier always hits. The result is registered.
module family_match #(
    parameter int unsigned ID_W    = 8,
    parameter int unsigned FIELD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] stored,
    input  logic            req_valid,
    input  logic            req_has_id,
    input  logic [ID_W-1:0] req_id,
    output logic            done,
    output logic            hit
);
    localparam int unsigned NUM_FIELDS = ID_W / FIELD_W;

    logic [NUM_FIELDS-1:0] field_ok;

    // One comparator per field, with zero acting as a wildcard.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] rq;
        logic [FIELD_W-1:0] st;
        assign rq = req_id[f*FIELD_W +: FIELD_W];
        assign st = stored[f*FIELD_W +: FIELD_W];
        assign field_ok[f] = (rq == '0) || (rq == st);
    end

    // Register the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            hit  <= 1'b0;
        end else begin
            done <= req_valid;
            hit  <= req_valid && (!req_has_id || (&field_ok));
        end
    end
endmodule

// File: rtl/tag_ident_regs.sv
// Module: top of the tag identifier block. It holds the family and format
// write-once registers and the family match for selection requests.
// Assumes both registers share one data bus with separate strobes, and that
// the match reads the family value held before any write in the same cycle.
module tag_ident_regs
    import tag_ident_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fam_wr,
    input  logic            fmt_wr,
    input  logic [ID_W-1:0] wr_byte,
    output logic [ID_W-1:0] fam_id,
    output logic [ID_W-1:0] fmt_id,
    output logic            fam_lock,
    output logic            fmt_lock,
    output logic            fam_wr_err,
    output logic            fmt_wr_err,
    input  logic            sel_valid,
    input  logic            sel_has_id,
    input  logic [ID_W-1:0] sel_id,
    output logic            sel_done,
    output logic            sel_hit
);
    logic [NUM_REGS-1:0]           wr_vec;
    logic [NUM_REGS-1:0][ID_W-1:0] val_vec;
    logic [NUM_REGS-1:0]           lock_vec;
    logic [NUM_REGS-1:0]           err_vec;

    assign wr_vec[REG_FAM] = fam_wr;
    assign wr_vec[REG_FMT] = fmt_wr;

    // One write-once register per identifier.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        wo_byte_reg #(.W(ID_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_vec[i]),
            .din    (wr_byte),
            .value  (val_vec[i]),
            .locked (lock_vec[i]),
            .err    (err_vec[i])
        );
    end

    assign fam_id     = val_vec[REG_FAM];
    assign fmt_id     = val_vec[REG_FMT];
    assign fam_lock   = lock_vec[REG_FAM];
    assign fmt_lock   = lock_vec[REG_FMT];
    assign fam_wr_err = err_vec[REG_FAM];
    assign fmt_wr_err = err_vec[REG_FMT];

    family_match #(.ID_W(ID_W), .FIELD_W(FIELD_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .stored     (val_vec[REG_FAM]),
        .req_valid  (sel_valid),
        .req_has_id (sel_has_id),
        .req_id     (sel_id),
        .done       (sel_done),
        .hit        (sel_hit)
    );
endmodule

// File: rtl/tag_ident_regs_chk.sv
// Module: checker bound to tag_ident_regs. It watches the port behaviour
// over time: locks stay set, locked values do not move, error pulses follow
// locked writes, and match results follow requests by one cycle.
module tag_ident_regs_chk #(
    parameter int unsigned ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fam_wr,
    input logic            fmt_wr,
    input logic [ID_W-1:0] fam_id,
    input logic [ID_W-1:0] fmt_id,
    input logic            fam_lock,
    input logic            fmt_lock,
    input logic            fam_wr_err,
    input logic            fmt_wr_err,
    input logic            sel_valid,
    input logic            sel_has_id,
    input logic            sel_done,
    input logic            sel_hit
);
    p_fam_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fam_lock |=> fam_lock);
    p_fam_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fam_lock |=> $stable(fam_id));
    p_fam_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_wr && fam_lock) |=> fam_wr_err);
    p_fmt_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_lock |=> fmt_lock);
    p_fmt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_lock |=> $stable(fmt_id));
    p_fmt_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_wr && fmt_lock) |=> fmt_wr_err);
    p_fam_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fam_wr) |=> !fam_wr_err);
    p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> sel_done);
    p_hit_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> sel_done);
    p_no_id_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_has_id) |=> sel_hit);
endmodule

bind tag_ident_regs tag_ident_regs_chk #(.ID_W(tag_ident_pkg::ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fam_wr     (fam_wr),
    .fmt_wr     (fmt_wr),
    .fam_id     (fam_id),
    .fmt_id     (fmt_id),
    .fam_lock   (fam_lock),
    .fmt_lock   (fmt_lock),
    .fam_wr_err (fam_wr_err),
    .fmt_wr_err (fmt_wr_err),
    .sel_valid  (sel_valid),
    .sel_has_id (sel_has_id),
    .sel_done   (sel_done),
    .sel_hit    (sel_hit)
);

// File: tb/tag_ident_regs_test.sv
// Bench: a behavioural model updated on each rising edge and compared with
// the design on every falling edge. Stimulus is also applied on falling edges.
module tag_ident_regs_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fam_wr = 1'b0, fmt_wr = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] fam_id, fmt_id;
    logic       fam_lock, fmt_lock, fam_wr_err, fmt_wr_err;
    logic       sel_valid = 1'b0, sel_has_id = 1'b0;
    logic [7:0] sel_id = 8'h00;
    logic       sel_done, sel_hit;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    string hit_tag = "R8";

    // Reference model state.
    int  m_fam = 0, m_fmt = 0;
    bit  m_fam_lk = 0, m_fmt_lk = 0;
    bit  m_fam_err = 0, m_fmt_err = 0;
    bit  m_done = 0, m_hit = 0;

    tag_ident_regs uut (
        .clk(clk), .rst_n(rst_n), .fam_wr(fam_wr), .fmt_wr(fmt_wr),
        .wr_byte(wr_byte), .fam_id(fam_id), .fmt_id(fmt_id),
        .fam_lock(fam_lock), .fmt_lock(fmt_lock),
        .fam_wr_err(fam_wr_err), .fmt_wr_err(fmt_wr_err),
        .sel_valid(sel_valid), .sel_has_id(sel_has_id), .sel_id(sel_id),
        .sel_done(sel_done), .sel_hit(sel_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Model: every result lands one rising edge after its stimulus.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_fam = 0; m_fmt = 0; m_fam_lk = 0; m_fmt_lk = 0;
            m_fam_err = 0; m_fmt_err = 0; m_done = 0; m_hit = 0;
        end else begin
            int hi_rq, lo_rq, hi_st, lo_st;
            hi_rq = int'(sel_id) / 16; lo_rq = int'(sel_id) % 16;
            hi_st = m_fam / 16;        lo_st = m_fam % 16;
            m_done = sel_valid;
            m_hit  = sel_valid && (!sel_has_id ||
                     ((hi_rq == 0 || hi_rq == hi_st) && (lo_rq == 0 || lo_rq == lo_st)));
            m_fam_err = fam_wr && m_fam_lk;
            m_fmt_err = fmt_wr && m_fmt_lk;
            if (fam_wr && !m_fam_lk) begin m_fam = int'(wr_byte); m_fam_lk = 1; end
            if (fmt_wr && !m_fmt_lk) begin m_fmt = int'(wr_byte); m_fmt_lk = 1; end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check("R2 fam_id",     int'(fam_id),     m_fam);
            check("R2 fam_lock",   int'(fam_lock),   int'(m_fam_lk));
            check("R3 fam_wr_err", int'(fam_wr_err), int'(m_fam_err));
            check("R4 fmt_id",     int'(fmt_id),     m_fmt);
            check("R4 fmt_lock",   int'(fmt_lock),   int'(m_fmt_lk));
            check("R5 fmt_wr_err", int'(fmt_wr_err), int'(m_fmt_err));
            check("R7 sel_done",   int'(sel_done),   int'(m_done));
            check({hit_tag, " sel_hit"}, int'(sel_hit), int'(m_hit));
        end
    end

    task automatic idle();
        @(negedge clk);
        fam_wr = 0; fmt_wr = 0; sel_valid = 0; sel_has_id = 0; sel_id = 8'h00;
    endtask

    task automatic wr(input bit f, input bit m, input logic [7:0] d);
        @(negedge clk);
        fam_wr = f; fmt_wr = m; wr_byte = d; sel_valid = 0;
    endtask

    task automatic req(input string tag, input bit has, input logic [7:0] id);
        @(negedge clk);
        hit_tag = tag; fam_wr = 0; fmt_wr = 0;
        sel_valid = 1; sel_has_id = has; sel_id = id;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear during reset.
        check("R1 reset fam_id",   int'(fam_id),   0);
        check("R1 reset locks",    int'({fam_lock, fmt_lock}), 0);
        check("R1 reset errs",     int'({fam_wr_err, fmt_wr_err}), 0);
        check("R1 reset sel",      int'({sel_done, sel_hit}), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        idle();
        // Blank tag: zero request hits, specific one misses (R8, R9).
        req("R8", 1, 8'h00);
        req("R8", 1, 8'h10);
        req("R9", 1, 8'h01);
        // R11: request and first family write in the same cycle.
        @(negedge clk);
        hit_tag = "R11"; fam_wr = 1; wr_byte = 8'h35;
        sel_valid = 1; sel_has_id = 1; sel_id = 8'h35;
        req("R11", 1, 8'h35);
        idle();
        // R3: locked rewrites, back to back, value must hold.
        wr(1, 0, 8'h77);
        wr(1, 0, 8'h00);
        idle();
        idle();
        // R8/R9 matching against 0x35.
        req("R8", 1, 8'h30);
        req("R8", 1, 8'h40);
        req("R9", 1, 8'h05);
        req("R9", 1, 8'h06);
        req("R9", 1, 8'h36);
        req("R9", 1, 8'h35);
        req("R8", 1, 8'h25);
        // R10: no identifier carried.
        req("R10", 0, 8'hFF);
        req("R10", 0, 8'h12);
        idle();
        // R4 then R5 on the format register; R6 independence.
        wr(0, 1, 8'hA2);
        wr(0, 1, 8'h00);
        idle();
        check("R6 fam untouched", int'(fam_id), 8'h35);
        wr(1, 1, 8'h5C);
        idle();
        idle();
        check("R6 both errs pulsed once", int'({fam_wr_err, fmt_wr_err}), 0);
        check("R5 fmt held", int'(fmt_id), 8'hA2);
        req("R7", 1, 8'h35);
        idle();
        idle();
        // Reset mid-run clears everything again (R1).
        @(negedge clk);
        compare_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 re-reset locks", int'({fam_lock, fmt_lock}), 0);
        check("R1 re-reset ids",   int'({fam_id, fmt_id}), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        // R6: format only, family stays blank and unlocked.
        wr(0, 1, 8'h11);
        idle();
        check("R6 fam still unlocked", int'(fam_lock), 0);
        idle();
        finish_run();
    end
endmodule